// File: doc/BRIEF.md
# Shared-Unit Biquad Filter Datapath

This block computes one second-order IIR section (direct form II, two delay words) on a stream of 16-bit Q1.15 samples. It uses one adder and one multiplier for all the arithmetic. Each functional unit has its own operand registers, so no two operations are chained in one cycle. Every operand register, every storage register and the output register loads from a private bus. A bus carries exactly one selected source each step: a unit result, a storage register, the input sample, or one of five coefficient patterns that are fixed in the logic.

A free-running sequencer with no feedback from the datapath steps through a fixed 13-step iteration. In each step it raises the drive and load enables for that step. A sample is taken only in step 0. The filtered result is presented with a one-cycle valid pulse in step 12 of the same iteration. If no sample is offered in step 0, that iteration runs idle: the delay words and the output register are left untouched and no valid pulse appears.

The recurrence is w = x + (-a1)·w1 + (-a2)·w2, y = b0·w + b1·w1 + b2·w2, followed by w2 ← w1 and w1 ← w. The negated feedback coefficients are the ones hardwired into the logic.

Top module: `biquad_shared`

## Requirements
- R1: While reset is held and in the first cycle after it, in_ready is 1, out_valid is 0 and out_data is 0. Both delay words start at zero.
- R2: in_ready is high in exactly one cycle out of every 13, starting with the first cycle after reset.
- R3: A sample is captured only when in_valid and in_ready are both high. in_valid and in_data in any other cycle have no effect on any output.
- R4: For a captured sample, out_valid is high for exactly one cycle, 12 cycles after the capturing clock edge. out_valid is low in all other cycles.
- R5: out_data equals the direct-form-II recurrence applied to the captured samples in order. It is stable from 7 cycles after the capturing edge until the next update.
- R6: Each product is the 32-bit signed product of two Q1.15 words, truncated to bits [30:15]. For example, (-1)·(-1) gives 16'h8000.
- R7: Each addition wraps modulo 2^16, with no saturation.
- R8: An iteration whose step 0 sees in_valid low gives no out_valid pulse. It leaves out_data and both delay words unchanged.
- R9: In every step, each bus has at most one enabled source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample offered |
| in_data | input | 16 | Input sample, Q1.15 |
| in_ready | output | 1 | High in step 0, the only step in which a sample is taken |
| out_valid | output | 1 | One-cycle pulse in step 12 of an iteration that took a sample |
| out_data | output | 16 | Filter output, Q1.15, held between updates |

## Verification
The capturing edge is the rising edge that ends the in_ready cycle. The result register loads at the edge that ends step 6, so out_data is due 7 cycles after the capturing edge, and the valid pulse comes 12 cycles after it. The bench runs each iteration as 13 falling-edge samples counted from the in_ready cycle. At each sample it checks in_ready and out_valid against their expected positions, and it compares out_data against an arithmetic Q1.15 model in every cycle from the seventh onward. Idle iterations and in_valid junk outside step 0 are checked over the same window, using the previously expected output.

// File: rtl/bqs_pkg.sv
package bqs_pkg;
    localparam int DW      = 16;
    localparam int STEPS   = 13;
    localparam int STEP_W  = $clog2(STEPS);
    localparam int NSTORE  = 4;

    // source indices
    localparam int SRC_MUL = 0;
    localparam int SRC_ADD = 1;
    localparam int SRC_S0  = 2;               // SRC_S0 .. SRC_S0+NSTORE-1
    localparam int SRC_X   = SRC_S0 + NSTORE;
    localparam int SRC_B0  = SRC_X + 1;
    localparam int SRC_B1  = SRC_X + 2;
    localparam int SRC_B2  = SRC_X + 3;
    localparam int SRC_NA1 = SRC_X + 4;
    localparam int SRC_NA2 = SRC_X + 5;
    localparam int NSRC    = SRC_NA2 + 1;

    // bus indices (one private bus per loadable register)
    localparam int BUS_MA  = 0;
    localparam int BUS_MB  = 1;
    localparam int BUS_AA  = 2;
    localparam int BUS_AB  = 3;
    localparam int BUS_S0  = 4;               // BUS_S0 .. BUS_S0+NSTORE-1
    localparam int BUS_OUT = BUS_S0 + NSTORE;
    localparam int NBUS    = BUS_OUT + 1;

    typedef logic signed [DW-1:0] word_t;

    typedef struct packed {
        logic [NBUS-1:0][NSRC-1:0] drv;   // per bus, per source drive enable
        logic [NBUS-1:0]           ld;    // per bus, register load enable
        logic                      take;  // sample acceptance step
        logic                      last;  // final step of the iteration
    } step_ctrl_t;

    // Q1.15 product: full 2*DW signed product, keep bits [2*DW-2:DW-1]
    function automatic word_t q15_mul(word_t a, word_t b);
        logic signed [2*DW-1:0] p;
        p = a * b;
        return p[2*DW-2:DW-1];
    endfunction
endpackage

// File: rtl/bqs_sequencer.sv
module bqs_sequencer
    import bqs_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    output step_ctrl_t ctrl
);
    logic [STEP_W-1:0] step;

    always_ff @(posedge clk) begin
        if (rst)                               step <= '0;
        else if (step == STEP_W'(STEPS - 1))   step <= '0;
        else                                   step <= step + 1'b1;
    end

    always_comb begin
        ctrl      = '0;
        ctrl.take = (step == '0);
        ctrl.last = (step == STEP_W'(STEPS - 1));
        case (step)
            STEP_W'(0): begin
                ctrl.drv[BUS_MA][SRC_S0]     = 1'b1;   // w1
                ctrl.drv[BUS_MB][SRC_NA1]    = 1'b1;
            end
            STEP_W'(1): begin
                ctrl.drv[BUS_AA][SRC_MUL]    = 1'b1;   // -a1*w1
                ctrl.drv[BUS_AB][SRC_X]      = 1'b1;
                ctrl.drv[BUS_MA][SRC_S0+1]   = 1'b1;   // w2
                ctrl.drv[BUS_MB][SRC_NA2]    = 1'b1;
            end
            STEP_W'(2): begin
                ctrl.drv[BUS_AA][SRC_ADD]    = 1'b1;   // x - a1*w1
                ctrl.drv[BUS_AB][SRC_MUL]    = 1'b1;   // -a2*w2
                ctrl.drv[BUS_MA][SRC_S0]     = 1'b1;
                ctrl.drv[BUS_MB][SRC_B1]     = 1'b1;
            end
            STEP_W'(3): begin
                ctrl.drv[BUS_S0+2][SRC_ADD]  = 1'b1;   // w
                ctrl.drv[BUS_S0+3][SRC_MUL]  = 1'b1;   // b1*w1
                ctrl.drv[BUS_MA][SRC_S0+1]   = 1'b1;
                ctrl.drv[BUS_MB][SRC_B2]     = 1'b1;
            end
            STEP_W'(4): begin
                ctrl.drv[BUS_AA][SRC_MUL]    = 1'b1;   // b2*w2
                ctrl.drv[BUS_AB][SRC_S0+3]   = 1'b1;
                ctrl.drv[BUS_MA][SRC_S0+2]   = 1'b1;
                ctrl.drv[BUS_MB][SRC_B0]     = 1'b1;
            end
            STEP_W'(5): begin
                ctrl.drv[BUS_AA][SRC_ADD]    = 1'b1;   // b1*w1 + b2*w2
                ctrl.drv[BUS_AB][SRC_MUL]    = 1'b1;   // b0*w
                ctrl.drv[BUS_S0+1][SRC_S0]   = 1'b1;   // w2 <= w1
                ctrl.drv[BUS_S0][SRC_S0+2]   = 1'b1;   // w1 <= w
            end
            STEP_W'(6): begin
                ctrl.drv[BUS_OUT][SRC_ADD]   = 1'b1;   // y
            end
            default: ;
        endcase
        for (int b = 0; b < NBUS; b++) ctrl.ld[b] = |ctrl.drv[b];
    end
endmodule

// File: rtl/bqs_bus.sv
module bqs_bus
    import bqs_pkg::*;
#(
    parameter int NS = NSRC
)(
    input  logic               clk,
    input  logic               rst,
    input  word_t [NS-1:0]     srcs,
    input  logic  [NS-1:0]     sel,
    output word_t              bus
);
    always_comb begin
        bus = '0;
        for (int s = 0; s < NS; s++)
            if (sel[s]) bus = bus | srcs[s];
    end

    // R9: no step may enable two drivers on one bus
    assert_single_driver_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
endmodule

// File: rtl/bqs_units.sv
module bqs_units
    import bqs_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  word_t bus_ma,
    input  word_t bus_mb,
    input  word_t bus_aa,
    input  word_t bus_ab,
    input  logic  ld_ma,
    input  logic  ld_mb,
    input  logic  ld_aa,
    input  logic  ld_ab,
    output word_t prod,
    output word_t sum
);
    word_t op_ma, op_mb, op_aa, op_ab;

    always_ff @(posedge clk) begin
        if (rst) begin
            op_ma <= '0;
            op_mb <= '0;
            op_aa <= '0;
            op_ab <= '0;
        end else begin
            if (ld_ma) op_ma <= bus_ma;
            if (ld_mb) op_mb <= bus_mb;
            if (ld_aa) op_aa <= bus_aa;
            if (ld_ab) op_ab <= bus_ab;
        end
    end

    assign prod = q15_mul(op_ma, op_mb);
    assign sum  = op_aa + op_ab;

    assert_prod_trunc_R6: assert property (@(posedge clk) disable iff (rst)
        (ld_ma && ld_mb) |=> prod == q15_mul($past(bus_ma), $past(bus_mb)));

    assert_sum_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (ld_aa && ld_ab) |=> sum == word_t'($past(bus_aa) + $past(bus_ab)));
endmodule

// File: rtl/biquad_shared.sv
module biquad_shared
    import bqs_pkg::*;
#(
    parameter logic [DW-1:0] COEF_B0  = 16'h2000,
    parameter logic [DW-1:0] COEF_B1  = 16'h4000,
    parameter logic [DW-1:0] COEF_B2  = 16'h8000,
    parameter logic [DW-1:0] COEF_NA1 = 16'h7333,
    parameter logic [DW-1:0] COEF_NA2 = 16'hCCCD
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_data,
    output logic          in_ready,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);
    step_ctrl_t          ctrl;
    logic [NBUS-1:0]     ld_eff;
    logic                live;
    word_t               x_reg;
    word_t               out_reg;
    word_t               store [NSTORE];
    word_t [NSRC-1:0]    srcs;
    word_t               bus_v [NBUS];
    word_t               prod, sum;

    bqs_sequencer u_seq (
        .clk  (clk),
        .rst  (rst),
        .ctrl (ctrl)
    );

    // sample capture and iteration liveness
    always_ff @(posedge clk) begin
        if (rst) begin
            live  <= 1'b0;
            x_reg <= '0;
        end else if (ctrl.take) begin
            live <= in_valid;
            if (in_valid) x_reg <= word_t'(in_data);
        end
    end

    // an idle iteration must not disturb the delay words or the result
    always_comb begin
        ld_eff = ctrl.ld;
        if (!live) begin
            ld_eff[BUS_S0]   = 1'b0;
            ld_eff[BUS_S0+1] = 1'b0;
            ld_eff[BUS_OUT]  = 1'b0;
        end
    end

    // source collection
    always_comb begin
        srcs          = '0;
        srcs[SRC_MUL] = prod;
        srcs[SRC_ADD] = sum;
        for (int g = 0; g < NSTORE; g++) srcs[SRC_S0+g] = store[g];
        srcs[SRC_X]   = x_reg;
        srcs[SRC_B0]  = word_t'(COEF_B0);
        srcs[SRC_B1]  = word_t'(COEF_B1);
        srcs[SRC_B2]  = word_t'(COEF_B2);
        srcs[SRC_NA1] = word_t'(COEF_NA1);
        srcs[SRC_NA2] = word_t'(COEF_NA2);
    end

    for (genvar b = 0; b < NBUS; b++) begin : g_bus
        bqs_bus #(.NS(NSRC)) u_bus (
            .clk  (clk),
            .rst  (rst),
            .srcs (srcs),
            .sel  (ctrl.drv[b]),
            .bus  (bus_v[b])
        );
    end

    bqs_units u_units (
        .clk    (clk),
        .rst    (rst),
        .bus_ma (bus_v[BUS_MA]),
        .bus_mb (bus_v[BUS_MB]),
        .bus_aa (bus_v[BUS_AA]),
        .bus_ab (bus_v[BUS_AB]),
        .ld_ma  (ld_eff[BUS_MA]),
        .ld_mb  (ld_eff[BUS_MB]),
        .ld_aa  (ld_eff[BUS_AA]),
        .ld_ab  (ld_eff[BUS_AB]),
        .prod   (prod),
        .sum    (sum)
    );

    for (genvar g = 0; g < NSTORE; g++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst)                   store[g] <= '0;
            else if (ld_eff[BUS_S0+g]) store[g] <= bus_v[BUS_S0+g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)                  out_reg <= '0;
        else if (ld_eff[BUS_OUT]) out_reg <= bus_v[BUS_OUT];
    end

    assign in_ready  = ctrl.take;
    assign out_valid = ctrl.last & live;
    assign out_data  = out_reg;

    assert_ready_gap_R2: assert property (@(posedge clk) disable iff (rst)
        in_ready |=> !in_ready);

    assert_valid_then_ready_R4: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> in_ready);

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> !live);

    assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !live |=> $stable(out_data));
endmodule

// File: tb/biquad_shared_test.sv
module biquad_shared_test;
    localparam logic [15:0] B0  = 16'h2000;
    localparam logic [15:0] B1  = 16'h4000;
    localparam logic [15:0] B2  = 16'h8000;
    localparam logic [15:0] NA1 = 16'h7333;
    localparam logic [15:0] NA2 = 16'hCCCD;
    localparam int ITERS = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready, out_valid;
    logic [15:0] out_data;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    biquad_shared #(.COEF_B0(B0), .COEF_B1(B1), .COEF_B2(B2),
                    .COEF_NA1(NA1), .COEF_NA2(NA2)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data));

    function automatic logic [15:0] qmul(logic [15:0] a, logic [15:0] b);
        logic signed [31:0] p;
        p = $signed(a) * $signed(b);
        return p[30:15];
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    logic [15:0] w1 = '0, w2 = '0, ey = '0, lfsr = 16'hACE1;

    function automatic logic [15:0] lfsr_next(logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 in_ready", {15'd0, in_ready}, 16'd1);
        check("R1 out_valid", {15'd0, out_valid}, 16'd0);
        check("R1 out_data", out_data, 16'd0);
        rst = 1'b0;
        // first cycle after reset: step 0
        check("R1 out_data after release", out_data, 16'd0);
        for (int it = 0; it < ITERS; it++) begin
            logic vld;
            logic junk;
            logic [15:0] x;
            string tag;
            if (it > 0) @(negedge clk);
            // stimulus plan per phase
            vld = 1'b1; junk = 1'b0;
            if (it < 12) begin
                x = (it == 0) ? 16'h7FFF : 16'h0000;  tag = "R5,R9";
            end else if (it < 24) begin
                x = 16'h8000;                          tag = "R6";
            end else if (it < 36) begin
                x = it[0] ? 16'h7FFF : 16'h8000;       tag = "R7";
            end else begin
                lfsr = lfsr_next(lfsr);
                x = lfsr;
                if (it % 5 == 0) begin vld = 1'b0; tag = "R8"; end
                else if (it[0])  begin junk = 1'b1; tag = "R3"; end
                else tag = "R5";
            end
            check("R2 in_ready in step 0", {15'd0, in_ready}, 16'd1);
            in_valid = vld;
            in_data  = x;
            if (vld) begin
                logic [15:0] w;
                w  = x + qmul(NA1, w1) + qmul(NA2, w2);
                ey = qmul(B1, w1) + qmul(B2, w2) + qmul(B0, w);
                w2 = w1;
                w1 = w;
            end
            for (int i = 1; i < 13; i++) begin
                @(negedge clk);
                lfsr     = lfsr_next(lfsr);
                in_valid = junk;
                in_data  = lfsr;
                check("R2 in_ready off step 0", {15'd0, in_ready}, 16'd0);
                check((vld ? "R4 out_valid" : "R8 out_valid"),
                      {15'd0, out_valid}, {15'd0, (i == 12) && vld});
                if (i >= 7) check(tag, out_data, ey);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule